// File: doc/BRIEF.md
# PCIe Root Port Interrupt Aggregator

This block gathers every error and power-management event source of a PCI Express root port into a single level-sensitive interrupt request. The request goes to a programmable interrupt controller. Hardware event pulses set sticky status bits. Software clears a status bit by writing 1 to it. Each status bit reaches the interrupt only when its own combination of enables allows it. Depending on the source, that combination is an OR of a reporting enable and a system-error enable, a per-bit mask, a severity class, or a plain enable.

Software reaches all qualifying state through a small word-addressed register port. The write strobe takes effect in one cycle, and reads return data combinationally. After reset every enable is zero, so the interrupt stays low until software turns a source on. The final request is the OR of all qualified sources. It is registered once before it leaves the block.

Top module: `pcie_rp_irq_agg`

## Requirements
- R1: After reset every register reads 0 and irq_o is low.
- R2: A status bit is set by a one-cycle event pulse on its input and stays set. Writing 1 to it clears it, and writing 0 leaves it unchanged. An event that arrives in the same cycle as a clear of the same bit leaves the bit set.
- R3: irq_o is registered and follows a change of any qualified source exactly one clock edge later. It stays high as long as any qualified source remains.
- R4: The power-management source is active when root status [0] is set and root control [3] is set.
- R5: The received-message sources are active when a root error status bit and its paired enable agree. Bit [2] (fatal) pairs with root error command [2] or root control [2]. Bit [1] (non-fatal) pairs with root error command [1] or root control [1]. Bit [0] (correctable) pairs with root error command [0] or root control [0].
- R6: A correctable status bit is a source only when its correctable mask bit is 0 and root error command [0] is 1.
- R7: An uncorrectable status bit with a mask bit of 0 counts as fatal when its severity bit is 1, and as non-fatal when it is 0. A fatal bit needs device control [1] or command [0]. A non-fatal bit needs device control [0] or command [0].
- R8: The secondary sources are as follows. Secondary status [0] (master data parity) is a source when secondary mask [0] is 0 and command [1] is 1. Status [1] (signaled target abort) is a source when mask [1] is 0. Status [2] (received target abort) is a source when mask [2] is 0.
- R9: A power-management message status bit or an error detect bit is a source only when the bit at the same position in its enable register is 1.
- R10: The register map uses word addresses, and status registers are write-1-to-clear. Unused bits and unused addresses read 0, and writes to unused addresses have no effect. Control registers read back the value written. The map is:
  - 0: command ([0] system-error enable, [1] parity-error response)
  - 1: device control ([0] non-fatal report, [1] fatal report)
  - 2: root control ([0] correctable, [1] non-fatal and [2] fatal system-error enables, [3] PME interrupt enable)
  - 3: root error command ([0] correctable, [1] non-fatal, [2] fatal reporting)
  - 4: root status ([0] PME)
  - 5: root error status
  - 6 and 7: correctable status and mask
  - 8, 9 and 10: uncorrectable status, mask and severity
  - 11 and 12: secondary status and mask
  - 13 and 14: PME message status and enable
  - 15 and 16: error detect status and enable

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| evt_pme_i | input | 1 | PME status event pulse |
| evt_rmsg_i | input | 3 | Received message events ([0] correctable, [1] non-fatal, [2] fatal) |
| evt_cor_i | input | NCOR | Correctable error event pulses |
| evt_unc_i | input | NUNC | Uncorrectable error event pulses |
| evt_sec_i | input | 3 | Secondary status event pulses |
| evt_pmemsg_i | input | NPME | PME message detect pulses |
| evt_err_i | input | NERR | Error detect pulses |
| irq_o | output | 1 | Registered level interrupt request |

## Verification
Directed sequences turn on one source at a time through each alternative enable, and show that either side of an OR is sufficient. Uncorrectable errors are run with the severity bit at both values, so that a fatal-path enable never lets a non-fatal bit through and the reverse never happens either. A set coinciding with a clear separates set priority from clear priority. A long random mix of sparse writes, clears and event pulses follows, checked against a bench model of the whole register state. This mix exposes cross-wired enables, wrong bit positions and a missing or extra cycle of latency.

// File: rtl/pcie_rp_irq_pkg.sv
package pcie_rp_irq_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CMD    = 5'd0;
  localparam logic [ADDR_W-1:0] A_DEVCTL = 5'd1;
  localparam logic [ADDR_W-1:0] A_RCTL   = 5'd2;
  localparam logic [ADDR_W-1:0] A_RECMD  = 5'd3;
  localparam logic [ADDR_W-1:0] A_RSTAT  = 5'd4;
  localparam logic [ADDR_W-1:0] A_RERR   = 5'd5;
  localparam logic [ADDR_W-1:0] A_CORST  = 5'd6;
  localparam logic [ADDR_W-1:0] A_CORMSK = 5'd7;
  localparam logic [ADDR_W-1:0] A_UNCST  = 5'd8;
  localparam logic [ADDR_W-1:0] A_UNCMSK = 5'd9;
  localparam logic [ADDR_W-1:0] A_UNCSEV = 5'd10;
  localparam logic [ADDR_W-1:0] A_SECST  = 5'd11;
  localparam logic [ADDR_W-1:0] A_SECMSK = 5'd12;
  localparam logic [ADDR_W-1:0] A_PMEST  = 5'd13;
  localparam logic [ADDR_W-1:0] A_PMEEN  = 5'd14;
  localparam logic [ADDR_W-1:0] A_ERRST  = 5'd15;
  localparam logic [ADDR_W-1:0] A_ERREN  = 5'd16;

  // source index in the qualified vector
  localparam int unsigned S_PME    = 0;
  localparam int unsigned S_FMSG   = 1;
  localparam int unsigned S_NFMSG  = 2;
  localparam int unsigned S_CMSG   = 3;
  localparam int unsigned S_COR    = 4;
  localparam int unsigned S_UNCF   = 5;
  localparam int unsigned S_UNCNF  = 6;
  localparam int unsigned S_MDPE   = 7;
  localparam int unsigned S_STA    = 8;
  localparam int unsigned S_RTA    = 9;
  localparam int unsigned S_PMEMSG = 10;
  localparam int unsigned S_ERRDET = 11;
  localparam int unsigned NSRC     = 12;
endpackage

// File: rtl/rp_cfg_reg.sv
module rp_cfg_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  p_cfg_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/rp_sticky_bank.sv
module rp_sticky_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;
  end

  p_set_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

  p_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/rp_src_qualify.sv
module rp_src_qualify
  import pcie_rp_irq_pkg::*;
#(
  parameter int unsigned NCOR = 8,
  parameter int unsigned NUNC = 16,
  parameter int unsigned NPME = 4,
  parameter int unsigned NERR = 8
) (
  input  logic [1:0]      cmd_i,
  input  logic [1:0]      devctl_i,
  input  logic [3:0]      rctl_i,
  input  logic [2:0]      recmd_i,
  input  logic            rstat_i,
  input  logic [2:0]      rerr_i,
  input  logic [NCOR-1:0] cor_st_i,
  input  logic [NCOR-1:0] cor_msk_i,
  input  logic [NUNC-1:0] unc_st_i,
  input  logic [NUNC-1:0] unc_msk_i,
  input  logic [NUNC-1:0] unc_sev_i,
  input  logic [2:0]      sec_st_i,
  input  logic [2:0]      sec_msk_i,
  input  logic [NPME-1:0] pme_st_i,
  input  logic [NPME-1:0] pme_en_i,
  input  logic [NERR-1:0] err_st_i,
  input  logic [NERR-1:0] err_en_i,
  output logic [NSRC-1:0] src_o
);
  logic [NUNC-1:0] unc_fatal_hit, unc_nf_hit;

  for (genvar i = 0; i < NUNC; i++) begin : g_unc
    logic live;
    assign live             = unc_st_i[i] & ~unc_msk_i[i];
    assign unc_fatal_hit[i] = live &  unc_sev_i[i];
    assign unc_nf_hit[i]    = live & ~unc_sev_i[i];
  end

  logic serr_en;
  assign serr_en = cmd_i[0];

  always_comb begin
    src_o            = '0;
    src_o[S_PME]     = rstat_i & rctl_i[3];
    src_o[S_FMSG]    = rerr_i[2] & (recmd_i[2] | rctl_i[2]);
    src_o[S_NFMSG]   = rerr_i[1] & (recmd_i[1] | rctl_i[1]);
    src_o[S_CMSG]    = rerr_i[0] & (recmd_i[0] | rctl_i[0]);
    src_o[S_COR]     = (|(cor_st_i & ~cor_msk_i)) & recmd_i[0];
    src_o[S_UNCF]    = (|unc_fatal_hit) & (devctl_i[1] | serr_en);
    src_o[S_UNCNF]   = (|unc_nf_hit)    & (devctl_i[0] | serr_en);
    src_o[S_MDPE]    = sec_st_i[0] & ~sec_msk_i[0] & cmd_i[1];
    src_o[S_STA]     = sec_st_i[1] & ~sec_msk_i[1];
    src_o[S_RTA]     = sec_st_i[2] & ~sec_msk_i[2];
    src_o[S_PMEMSG]  = |(pme_st_i & pme_en_i);
    src_o[S_ERRDET]  = |(err_st_i & err_en_i);
  end
endmodule

// File: rtl/pcie_rp_irq_agg.sv
module pcie_rp_irq_agg
  import pcie_rp_irq_pkg::*;
#(
  parameter int unsigned NCOR = 8,
  parameter int unsigned NUNC = 16,
  parameter int unsigned NPME = 4,
  parameter int unsigned NERR = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              evt_pme_i,
  input  logic [2:0]        evt_rmsg_i,
  input  logic [NCOR-1:0]   evt_cor_i,
  input  logic [NUNC-1:0]   evt_unc_i,
  input  logic [2:0]        evt_sec_i,
  input  logic [NPME-1:0]   evt_pmemsg_i,
  input  logic [NERR-1:0]   evt_err_i,
  output logic              irq_o
);
  function automatic logic hit(input logic [ADDR_W-1:0] a);
    return reg_we_i && (reg_addr_i == a);
  endfunction

  logic [1:0]      cmd_q, devctl_q;
  logic [3:0]      rctl_q;
  logic [2:0]      recmd_q, rerr_q, sec_q, secmsk_q;
  logic [0:0]      rstat_q;
  logic [NCOR-1:0] cor_q, cormsk_q;
  logic [NUNC-1:0] unc_q, uncmsk_q, uncsev_q;
  logic [NPME-1:0] pme_q, pmeen_q;
  logic [NERR-1:0] err_q, erren_q;

  // control registers
  rp_cfg_reg #(.W(2)) u_cmd (.clk_i, .rst_ni, .we_i(hit(A_CMD)),
    .d_i(reg_wdata_i[1:0]), .q_o(cmd_q));
  rp_cfg_reg #(.W(2)) u_devctl (.clk_i, .rst_ni, .we_i(hit(A_DEVCTL)),
    .d_i(reg_wdata_i[1:0]), .q_o(devctl_q));
  rp_cfg_reg #(.W(4)) u_rctl (.clk_i, .rst_ni, .we_i(hit(A_RCTL)),
    .d_i(reg_wdata_i[3:0]), .q_o(rctl_q));
  rp_cfg_reg #(.W(3)) u_recmd (.clk_i, .rst_ni, .we_i(hit(A_RECMD)),
    .d_i(reg_wdata_i[2:0]), .q_o(recmd_q));
  rp_cfg_reg #(.W(NCOR)) u_cormsk (.clk_i, .rst_ni, .we_i(hit(A_CORMSK)),
    .d_i(reg_wdata_i[NCOR-1:0]), .q_o(cormsk_q));
  rp_cfg_reg #(.W(NUNC)) u_uncmsk (.clk_i, .rst_ni, .we_i(hit(A_UNCMSK)),
    .d_i(reg_wdata_i[NUNC-1:0]), .q_o(uncmsk_q));
  rp_cfg_reg #(.W(NUNC)) u_uncsev (.clk_i, .rst_ni, .we_i(hit(A_UNCSEV)),
    .d_i(reg_wdata_i[NUNC-1:0]), .q_o(uncsev_q));
  rp_cfg_reg #(.W(3)) u_secmsk (.clk_i, .rst_ni, .we_i(hit(A_SECMSK)),
    .d_i(reg_wdata_i[2:0]), .q_o(secmsk_q));
  rp_cfg_reg #(.W(NPME)) u_pmeen (.clk_i, .rst_ni, .we_i(hit(A_PMEEN)),
    .d_i(reg_wdata_i[NPME-1:0]), .q_o(pmeen_q));
  rp_cfg_reg #(.W(NERR)) u_erren (.clk_i, .rst_ni, .we_i(hit(A_ERREN)),
    .d_i(reg_wdata_i[NERR-1:0]), .q_o(erren_q));

  // sticky status, write-1-to-clear
  rp_sticky_bank #(.W(1)) u_rstat (.clk_i, .rst_ni, .set_i(evt_pme_i),
    .clr_i(hit(A_RSTAT) ? reg_wdata_i[0:0] : 1'b0), .q_o(rstat_q));
  rp_sticky_bank #(.W(3)) u_rerr (.clk_i, .rst_ni, .set_i(evt_rmsg_i),
    .clr_i(hit(A_RERR) ? reg_wdata_i[2:0] : 3'b0), .q_o(rerr_q));
  rp_sticky_bank #(.W(NCOR)) u_cor (.clk_i, .rst_ni, .set_i(evt_cor_i),
    .clr_i(hit(A_CORST) ? reg_wdata_i[NCOR-1:0] : '0), .q_o(cor_q));
  rp_sticky_bank #(.W(NUNC)) u_unc (.clk_i, .rst_ni, .set_i(evt_unc_i),
    .clr_i(hit(A_UNCST) ? reg_wdata_i[NUNC-1:0] : '0), .q_o(unc_q));
  rp_sticky_bank #(.W(3)) u_sec (.clk_i, .rst_ni, .set_i(evt_sec_i),
    .clr_i(hit(A_SECST) ? reg_wdata_i[2:0] : 3'b0), .q_o(sec_q));
  rp_sticky_bank #(.W(NPME)) u_pme (.clk_i, .rst_ni, .set_i(evt_pmemsg_i),
    .clr_i(hit(A_PMEST) ? reg_wdata_i[NPME-1:0] : '0), .q_o(pme_q));
  rp_sticky_bank #(.W(NERR)) u_err (.clk_i, .rst_ni, .set_i(evt_err_i),
    .clr_i(hit(A_ERRST) ? reg_wdata_i[NERR-1:0] : '0), .q_o(err_q));

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i;

  logic [NSRC-1:0] src;

  rp_src_qualify #(.NCOR(NCOR), .NUNC(NUNC), .NPME(NPME), .NERR(NERR)) u_qual (
    .cmd_i(cmd_q), .devctl_i(devctl_q), .rctl_i(rctl_q), .recmd_i(recmd_q),
    .rstat_i(rstat_q[0]), .rerr_i(rerr_q),
    .cor_st_i(cor_q), .cor_msk_i(cormsk_q),
    .unc_st_i(unc_q), .unc_msk_i(uncmsk_q), .unc_sev_i(uncsev_q),
    .sec_st_i(sec_q), .sec_msk_i(secmsk_q),
    .pme_st_i(pme_q), .pme_en_i(pmeen_q),
    .err_st_i(err_q), .err_en_i(erren_q),
    .src_o(src)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |src;
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CMD:    reg_rdata_o[1:0]      = cmd_q;
      A_DEVCTL: reg_rdata_o[1:0]      = devctl_q;
      A_RCTL:   reg_rdata_o[3:0]      = rctl_q;
      A_RECMD:  reg_rdata_o[2:0]      = recmd_q;
      A_RSTAT:  reg_rdata_o[0:0]      = rstat_q;
      A_RERR:   reg_rdata_o[2:0]      = rerr_q;
      A_CORST:  reg_rdata_o[NCOR-1:0] = cor_q;
      A_CORMSK: reg_rdata_o[NCOR-1:0] = cormsk_q;
      A_UNCST:  reg_rdata_o[NUNC-1:0] = unc_q;
      A_UNCMSK: reg_rdata_o[NUNC-1:0] = uncmsk_q;
      A_UNCSEV: reg_rdata_o[NUNC-1:0] = uncsev_q;
      A_SECST:  reg_rdata_o[2:0]      = sec_q;
      A_SECMSK: reg_rdata_o[2:0]      = secmsk_q;
      A_PMEST:  reg_rdata_o[NPME-1:0] = pme_q;
      A_PMEEN:  reg_rdata_o[NPME-1:0] = pmeen_q;
      A_ERRST:  reg_rdata_o[NERR-1:0] = err_q;
      A_ERREN:  reg_rdata_o[NERR-1:0] = erren_q;
      default:  reg_rdata_o           = '0;
    endcase
  end

  p_irq_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src) |=> irq_o);
  p_irq_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|src) |=> !irq_o);
  p_pme_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rctl_q[3] |-> !src[S_PME]);
  p_cor_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !recmd_q[0] |-> !src[S_COR]);
  p_uncf_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((uncsev_q & unc_q & ~uncmsk_q) == '0) |-> !src[S_UNCF]);
  p_evt_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erren_q == '0) |-> !src[S_ERRDET]);
endmodule

// File: tb/sim_pcie_rp_irq_agg.sv
module sim_pcie_rp_irq_agg;
  localparam int NCOR = 8, NUNC = 16, NPME = 4, NERR = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        evt_pme_i = 1'b0;
  logic [2:0]  evt_rmsg_i = '0;
  logic [NCOR-1:0] evt_cor_i = '0;
  logic [NUNC-1:0] evt_unc_i = '0;
  logic [2:0]  evt_sec_i = '0;
  logic [NPME-1:0] evt_pmemsg_i = '0;
  logic [NERR-1:0] evt_err_i = '0;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] sh [0:16];

  always #10 clk_i = ~clk_i;

  pcie_rp_irq_agg #(.NCOR(NCOR), .NUNC(NUNC), .NPME(NPME), .NERR(NERR)) u0 (.*);

  function automatic logic [31:0] wmask(input int a);
    case (a)
      0, 1: return 32'h3;
      2: return 32'hF;
      3, 5, 11, 12: return 32'h7;
      4: return 32'h1;
      6, 7, 15, 16: return 32'hFF;
      8, 9, 10: return 32'hFFFF;
      13, 14: return 32'hF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic is_stat(input int a);
    return a == 4 || a == 5 || a == 6 || a == 8 || a == 11 || a == 13 || a == 15;
  endfunction

  function automatic logic exp_irq();
    logic [10:0] s;
    s[0]  = sh[4][0] & sh[2][3];
    s[1]  = sh[5][2] & (sh[3][2] | sh[2][2]);
    s[2]  = sh[5][1] & (sh[3][1] | sh[2][1]);
    s[3]  = sh[5][0] & (sh[3][0] | sh[2][0]);
    s[4]  = (|(sh[6] & ~sh[7])) & sh[3][0];
    s[5]  = (|(sh[8] & ~sh[9] & sh[10]))  & (sh[1][1] | sh[0][0]);
    s[6]  = (|(sh[8] & ~sh[9] & ~sh[10])) & (sh[1][0] | sh[0][0]);
    s[7]  = (sh[11][0] & ~sh[12][0] & sh[0][1]) | (sh[11][1] & ~sh[12][1])
          | (sh[11][2] & ~sh[12][2]);
    s[8]  = |(sh[13] & sh[14]);
    s[9]  = |(sh[15] & sh[16]);
    s[10] = 1'b0;
    return |s;
  endfunction

  function automatic logic [31:0] evset(input int a);
    case (a)
      4: return {31'b0, evt_pme_i};
      5: return {29'b0, evt_rmsg_i};
      6: return 32'(evt_cor_i);
      8: return 32'(evt_unc_i);
      11: return {29'b0, evt_sec_i};
      13: return 32'(evt_pmemsg_i);
      15: return 32'(evt_err_i);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  // one clock with the inputs as driven; irq checked one edge later
  task automatic cyc(input string tag);
    logic e;
    logic [31:0] nx [0:16];
    e = exp_irq();
    for (int a = 0; a < 17; a++) begin
      logic wr;
      wr = reg_we_i && (int'(reg_addr_i) == a);
      if (is_stat(a)) nx[a] = ((sh[a] & ~(wr ? reg_wdata_i : 32'h0)) | evset(a)) & wmask(a);
      else            nx[a] = wr ? (reg_wdata_i & wmask(a)) : sh[a];
    end
    @(posedge clk_i);
    for (int a = 0; a < 17; a++) sh[a] = nx[a];
    @(negedge clk_i);
    chk(tag, "irq", {31'b0, irq_o}, {31'b0, e});
    reg_we_i = 1'b0; evt_pme_i = 1'b0; evt_rmsg_i = '0; evt_cor_i = '0;
    evt_unc_i = '0; evt_sec_i = '0; evt_pmemsg_i = '0; evt_err_i = '0;
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag);
    reg_we_i = 1'b1; reg_addr_i = 5'(a); reg_wdata_i = d;
    cyc(tag);
  endtask

  task automatic rd(input int a, input string tag);
    reg_addr_i = 5'(a);
    #1;
    chk(tag, $sformatf("rd%0d", a), reg_rdata_o, (a < 17) ? sh[a] : 32'h0);
  endtask

  task automatic clear_all();
    for (int a = 0; a < 17; a++) wr(a, is_stat(a) ? 32'hFFFF_FFFF : 32'h0, "R2");
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd7411);
    for (int a = 0; a < 17; a++) sh[a] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 17; a++) rd(a, "R1");
    chk("R1", "irq", {31'b0, irq_o}, 32'h0);

    // R2 sticky, set beats clear, write 0 no effect
    evt_cor_i = 8'h08; cyc("R2");
    rd(6, "R2"); chk("R2", "cor", reg_rdata_o, 32'h08);
    evt_cor_i = 8'h08; wr(6, 32'h08, "R2");
    rd(6, "R2"); chk("R2", "setwins", reg_rdata_o, 32'h08);
    wr(6, 32'h0, "R2"); rd(6, "R2");
    wr(6, 32'h08, "R2"); rd(6, "R2"); chk("R2", "clr", reg_rdata_o, 32'h0);

    // R3/R4 latency and PME source
    wr(2, 32'h8, "R4");
    evt_pme_i = 1'b1; cyc("R3");
    chk("R3", "lag", {31'b0, irq_o}, 32'h0);
    cyc("R4"); chk("R4", "pme", {31'b0, irq_o}, 32'h1);
    cyc("R3"); chk("R3", "level", {31'b0, irq_o}, 32'h1);
    wr(2, 32'h0, "R4"); cyc("R4");
    chk("R4", "pme_off", {31'b0, irq_o}, 32'h0);
    clear_all();

    // R5 message sources through each alternative enable
    for (int b = 0; b < 3; b++) begin
      evt_rmsg_i = 3'(1 << b); cyc("R5"); cyc("R5");
      wr(3, 32'(1 << b), "R5"); cyc("R5");
      wr(3, 32'h0, "R5"); cyc("R5");
      wr(2, 32'(1 << b), "R5"); cyc("R5");
      wr(2, 32'(3'h7 & ~(3'(1 << b))), "R5"); cyc("R5");
      clear_all();
    end

    // R6 correctable mask and enable
    evt_cor_i = 8'h41; cyc("R6");
    wr(3, 32'h1, "R6"); cyc("R6");
    wr(7, 32'h01, "R6"); cyc("R6");
    wr(7, 32'h41, "R6"); cyc("R6");
    chk("R6", "masked", {31'b0, irq_o}, 32'h0);
    clear_all();

    // R7 severity split
    evt_unc_i = 16'h0010; cyc("R7");
    wr(1, 32'h2, "R7"); cyc("R7");
    chk("R7", "nf_on_fatal_en", {31'b0, irq_o}, 32'h0);
    wr(1, 32'h1, "R7"); cyc("R7");
    wr(10, 32'h0010, "R7"); cyc("R7");
    chk("R7", "fatal_on_nf_en", {31'b0, irq_o}, 32'h0);
    wr(1, 32'h0, "R7"); wr(0, 32'h1, "R7"); cyc("R7");
    wr(9, 32'h0010, "R7"); cyc("R7");
    clear_all();

    // R8 secondary sources
    evt_sec_i = 3'b001; cyc("R8"); cyc("R8");
    wr(0, 32'h2, "R8"); cyc("R8");
    wr(12, 32'h1, "R8"); cyc("R8");
    evt_sec_i = 3'b110; cyc("R8"); cyc("R8");
    wr(12, 32'h3, "R8"); cyc("R8");
    wr(12, 32'h7, "R8"); cyc("R8");
    clear_all();

    // R9 message / detect enables
    evt_pmemsg_i = 4'h4; evt_err_i = 8'h80; cyc("R9"); cyc("R9");
    wr(14, 32'h3, "R9"); cyc("R9");
    wr(14, 32'h4, "R9"); cyc("R9");
    wr(14, 32'h0, "R9"); wr(16, 32'h80, "R9"); cyc("R9");
    clear_all();

    // R10 readback and unused addresses
    wr(2, 32'hFFFF_FFFF, "R10"); rd(2, "R10");
    wr(20, 32'hFFFF_FFFF, "R10"); rd(20, "R10");
    for (int a = 0; a < 17; a++) rd(a, "R10");
    clear_all();

    // random mix
    for (int it = 0; it < 3000; it++) begin
      int r;
      r = int'($urandom % 4);
      if (r == 0) begin
        reg_we_i = 1'b1; reg_addr_i = 5'($urandom % 17);
        reg_wdata_i = $urandom & $urandom & $urandom;
        if (is_stat(int'(reg_addr_i))) reg_wdata_i = ~32'h0;
      end else if (r == 1) begin
        int sa;
        sa = int'($urandom % 7);
        reg_we_i = 1'b1;
        reg_addr_i = 5'((sa == 0) ? 4 : (sa == 1) ? 5 : (sa == 2) ? 6 :
                        (sa == 3) ? 8 : (sa == 4) ? 11 : (sa == 5) ? 13 : 15);
        reg_wdata_i = $urandom;
      end
      if ($urandom % 8 == 0) evt_pme_i = 1'b1;
      if ($urandom % 8 == 0) evt_rmsg_i = 3'($urandom);
      if ($urandom % 8 == 0) evt_cor_i = NCOR'($urandom & $urandom);
      if ($urandom % 8 == 0) evt_unc_i = NUNC'($urandom & $urandom & $urandom);
      if ($urandom % 8 == 0) evt_sec_i = 3'($urandom);
      if ($urandom % 8 == 0) evt_pmemsg_i = NPME'($urandom);
      if ($urandom % 8 == 0) evt_err_i = NERR'($urandom & $urandom);
      cyc("R3");
      rd(int'($urandom % 17), "R10");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog R3 got %h exp %h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule